// File: doc/BRIEF.md
# Byte-Register PWM Generator

A single-channel pulse-width output driven by a write-only bus of 8-bit registers. Software programs a 16-bit cycle length and a 16-bit high time. Both are counted in ticks of a slow time base, with one tick on each clock cycle where `tick_en` is high (nominally 8 MHz, 125 ns per tick). An enable flag and a 16-bit auto-off timeout complete the register set. The output is active-high. Each cycle starts high and drops after the programmed high-time count.

Each 16-bit quantity is written as two bytes. A high-byte write only parks the byte. The low-byte write joins it with the parked byte and makes the new value active in one step. Period and duty are therefore committed separately, and software interleaves the byte writes so that the two commits land close together. An auto-off timeout other than 0xFFFF counts down once per millisecond of ticks while the output runs, and clears the enable flag when it expires.

Top module: `bytereg_pwm`

## Requirements
- R1: While `rst_n` is low and after its release, `pwm_out` is low until software enables the block. Reset leaves period 0, duty 0, enable 0 and auto-off 0xFFFF (timer disabled).
- R2: When enabled with duty D below period P (both nonzero), every P ticks `pwm_out` is high for the first D ticks and low for the rest. A free-running counter returns to zero after it reaches P-1.
- R3: Address 0xA5 parks the period high byte and 0xA4 commits the period as {parked byte, written byte}. Address 0xA7 parks the duty high byte and 0xA6 commits the duty the same way. A high-byte write alone changes nothing at the output.
- R4: If the active duty is greater than or equal to the active period, `pwm_out` stays high for as long as the block is enabled.
- R5: An active duty of zero keeps `pwm_out` low.
- R6: A write to 0xA3 sets the enable flag from data bit 0 and ignores the other bits. With enable at 0, `pwm_out` is low.
- R7: An auto-off value of 0xFFFF never counts, so the output keeps running without limit.
- R8: Address 0xA1 parks the auto-off high byte and 0xA2 loads the full timeout and restarts the millisecond prescaler. While enabled, the timeout drops by one every TICKS_PER_MS ticks. The tick that takes it from 1 to 0, or any millisecond tick that finds it at 0, clears the enable flag.
- R9: With `tick_en` low, the cycle counter and the output hold still. Timing scales with the tick rate and not with the clock.
- R10: Writes to any address outside 0xA1 to 0xA7 leave the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One time-base tick per cycle where high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | Active-high PWM output |

## Verification
Any error in the active period, duty or cycle counter changes the number of high samples over a whole number of cycles. The bench counts these highs, so the error is visible within one programmed period. A lost or early commit from the byte staging shows up the same way, in the first period after the offending write. An error in the auto-off countdown shows up as the output dropping too early or never dropping, within the programmed number of milliseconds of ticks. The tests use a short millisecond so that this window stays small.

// File: rtl/bytereg_pwm_pkg.sv
// Package: shared address constants for the byte-register PWM.
// Assumes 8-bit register addresses; the values are the software-visible map.
package bytereg_pwm_pkg;
    localparam int          REG_W        = 8;
    localparam logic [7:0]  ADR_AOFF_HI  = 8'hA1;
    localparam logic [7:0]  ADR_AOFF_LO  = 8'hA2;
    localparam logic [7:0]  ADR_ENABLE   = 8'hA3;
    localparam logic [7:0]  ADR_PER_LO   = 8'hA4;
    localparam logic [7:0]  ADR_PER_HI   = 8'hA5;
    localparam logic [7:0]  ADR_DUTY_LO  = 8'hA6;
    localparam logic [7:0]  ADR_DUTY_HI  = 8'hA7;
endpackage

// File: rtl/bytereg_pwm_regs.sv
// Module: register decode. Parks high bytes and commits full values on the
// low-byte write. Holds the enable flag, which the auto-off expiry clears.
// Assumes CNT_W == 2*REG_W. A write to the enable register wins over an
// expiry in the same cycle.
module bytereg_pwm_regs
    import bytereg_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             expire,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] duty,
    output logic             enable,
    output logic             aoff_load,
    output logic [CNT_W-1:0] aoff_value
);
    localparam int HI_W = CNT_W - REG_W;

    logic [HI_W-1:0] per_hi_park, duty_hi_park, aoff_hi_park;

    // Decode of the auto-off load strobe and its full value.
    always_comb begin
        aoff_load  = wr_en && (wr_addr == ADR_AOFF_LO);
        aoff_value = {aoff_hi_park, wr_data};
    end

    // Parking registers for the high bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_hi_park  <= '0;
            duty_hi_park <= '0;
            aoff_hi_park <= '1;
        end else if (wr_en) begin
            if (wr_addr == ADR_PER_HI)  per_hi_park  <= wr_data[HI_W-1:0];
            if (wr_addr == ADR_DUTY_HI) duty_hi_park <= wr_data[HI_W-1:0];
            if (wr_addr == ADR_AOFF_HI) aoff_hi_park <= wr_data[HI_W-1:0];
        end
    end

    // Active period and duty, committed on their low-byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            duty   <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_PER_LO)  period <= {per_hi_park, wr_data};
            if (wr_addr == ADR_DUTY_LO) duty   <= {duty_hi_park, wr_data};
        end
    end

    // Enable flag: set or cleared by software, cleared by auto-off expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= 1'b0;
        else if (wr_en && (wr_addr == ADR_ENABLE))
            enable <= wr_data[0];
        else if (expire)
            enable <= 1'b0;
    end

    AST_HI_PARK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_PER_HI) |=> $stable(period)); // R3
    AST_LO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_DUTY_LO) |=> (duty[REG_W-1:0] == $past(wr_data))); // R3
    AST_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !(wr_en && wr_addr == ADR_ENABLE)) |=> !enable); // R8
endmodule

// File: rtl/bytereg_pwm_autooff.sv
// Module: auto-off timer. A prescaler divides ticks down to milliseconds,
// and the timeout counts down once per millisecond while enabled.
// Assumes the value all-ones means the timer is disabled. A load restarts
// the prescaler and masks expiry in that cycle.
module bytereg_pwm_autooff #(
    parameter int CNT_W        = 16,
    parameter int TICKS_PER_MS = 8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             enable,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    output logic             expire
);
    localparam int PS_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICKS_PER_MS - 1);
    localparam logic [CNT_W-1:0] OFF_CODE = '1;

    logic [PS_W-1:0]  ps_cnt;
    logic [CNT_W-1:0] remain;
    logic             ms_strobe;
    logic             armed;

    // Millisecond strobe and expiry condition.
    always_comb begin
        ms_strobe = enable && tick_en && (ps_cnt == PS_LAST) && !load;
        armed     = (remain != OFF_CODE);
        expire    = ms_strobe && armed && (remain <= CNT_W'(1));
    end

    // Prescaler: runs only while enabled, restarts on a load.
    always_ff @(posedge clk) begin
        if (!rst_n || load || !enable)
            ps_cnt <= '0;
        else if (tick_en)
            ps_cnt <= (ps_cnt == PS_LAST) ? '0 : ps_cnt + PS_W'(1);
    end

    // Remaining timeout: loaded by software, decremented each millisecond.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= OFF_CODE;
        else if (load)
            remain <= load_value;
        else if (ms_strobe && armed && (remain != '0))
            remain <= remain - CNT_W'(1);
    end

    AST_OFF_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (remain == OFF_CODE && !load) |=> (remain == OFF_CODE)); // R7
    AST_NO_EXPIRE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !expire); // R8
endmodule

// File: rtl/bytereg_pwm_core.sv
// Module: cycle counter and output compare. Counts ticks from 0 to
// period-1 and drives the output high while the count is below duty.
// Assumes period 0 or 1 holds the counter at 0. The output is registered.
module bytereg_pwm_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             enable,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm_out
);
    logic [CNT_W-1:0] cyc_cnt;
    logic             at_wrap;

    // Wrap detect; the >= also recovers from a period shrunk below the count.
    always_comb begin
        at_wrap = ({1'b0, cyc_cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, period};
    end

    // Cycle counter: held at zero while disabled, advances on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            cyc_cnt <= '0;
        else if (tick_en)
            cyc_cnt <= at_wrap ? '0 : cyc_cnt + CNT_W'(1);
    end

    // Registered output compare with normal polarity.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_out <= 1'b0;
        else
            pwm_out <= enable && (cyc_cnt < duty);
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !pwm_out); // R1
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pwm_out); // R6
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |=> !pwm_out); // R5
    AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && period != '0 && duty >= period && cyc_cnt < period) |=> pwm_out); // R4
    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick_en) |=> $stable(cyc_cnt)); // R9
endmodule

// File: rtl/bytereg_pwm.sv
// Module: top of the byte-register PWM generator. Joins the register
// decode, the auto-off timer and the output core.
// Assumes one write per cycle on the write-only byte bus.
module bytereg_pwm
    import bytereg_pwm_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int TICKS_PER_MS = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       pwm_out
);
    logic [CNT_W-1:0] period, duty, aoff_value;
    logic             enable, aoff_load, expire;

    bytereg_pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .expire     (expire),
        .period     (period),
        .duty       (duty),
        .enable     (enable),
        .aoff_load  (aoff_load),
        .aoff_value (aoff_value)
    );

    bytereg_pwm_autooff #(.CNT_W(CNT_W), .TICKS_PER_MS(TICKS_PER_MS)) u_aoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .enable     (enable),
        .load       (aoff_load),
        .load_value (aoff_value),
        .expire     (expire)
    );

    bytereg_pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .enable  (enable),
        .period  (period),
        .duty    (duty),
        .pwm_out (pwm_out)
    );
endmodule

// File: tb/sim_bytereg_pwm.sv
module sim_bytereg_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       pwm_out;

    int n_checks = 0;
    int n_fails  = 0;
    int tick_div = 1;   // 0: no ticks, N: one tick every N cycles
    int tick_ph  = 0;

    always #10 clk = ~clk;

    bytereg_pwm #(.CNT_W(16), .TICKS_PER_MS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
    );

    // Tick pattern generator, updated away from the active edge.
    always @(negedge clk) begin
        if (tick_div == 0) begin
            tick_en = 1'b0;
            tick_ph = 0;
        end else begin
            tick_en = (tick_ph == 0);
            tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_pd(input int p, input int d);
        wr(8'hA5, 8'(p >> 8));
        wr(8'hA7, 8'(d >> 8));
        wr(8'hA4, 8'(p));
        wr(8'hA6, 8'(d));
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
    endtask

    // Settle, then count highs over four whole periods.
    task automatic ratio(input int p, input int scale, output int highs);
        repeat (p * scale + 4) @(negedge clk);
        count_high(4 * p * scale, highs);
    endtask

    task automatic t_reset;
        int h;
        rst_n = 1'b0;
        count_high(5, h);
        rst_n = 1'b1;
        count_high(20, h);
        check("R1 output low through and after reset", h, 0);
    endtask

    task automatic t_basic;
        int h;
        set_pd(10, 3);
        wr(8'hA3, 8'h01);
        ratio(10, 1, h);
        check("R2 period 10 duty 3", h, 12);
        set_pd(261, 256);
        ratio(261, 1, h);
        check("R2 period 261 duty 256", h, 1024);
        set_pd(10, 3);
    endtask

    task automatic t_staging;
        int h;
        wr(8'hA5, 8'h01);
        wr(8'hA7, 8'h01);
        ratio(10, 1, h);
        check("R3 high bytes alone change nothing", h, 12);
        wr(8'hA4, 8'd20);
        ratio(276, 1, h);
        check("R3 period low commits parked high byte", h, 12);
        set_pd(10, 3);
        ratio(10, 1, h);
        check("R3 restored", h, 12);
    endtask

    task automatic t_full;
        int h;
        set_pd(10, 10);
        ratio(10, 1, h);
        check("R4 duty equal to period", h, 40);
        set_pd(10, 15);
        ratio(10, 1, h);
        check("R4 duty above period", h, 40);
    endtask

    task automatic t_zero;
        int h;
        set_pd(10, 0);
        ratio(10, 1, h);
        check("R5 zero duty", h, 0);
    endtask

    task automatic t_enable;
        int h;
        set_pd(10, 3);
        wr(8'hA3, 8'h00);
        ratio(10, 1, h);
        check("R6 enable 0 forces low", h, 0);
        wr(8'hA3, 8'h02);
        ratio(10, 1, h);
        check("R6 only bit 0 enables", h, 0);
        wr(8'hA3, 8'h03);
        ratio(10, 1, h);
        check("R6 bit 0 set runs", h, 12);
    endtask

    task automatic t_unmapped;
        int h;
        wr(8'hA0, 8'h00);
        wr(8'hA8, 8'h00);
        wr(8'h24, 8'h00);
        wr(8'h26, 8'h00);
        ratio(10, 1, h);
        check("R10 unmapped writes ignored", h, 12);
    endtask

    task automatic t_tick;
        int h;
        logic first;
        tick_div = 0;
        repeat (3) @(negedge clk);
        first = pwm_out;
        h = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_out != first) h++;
        end
        check("R9 output frozen without ticks", h, 0);
        tick_div = 3;
        ratio(10, 3, h);
        check("R9 one tick per three cycles", h, 36);
        tick_div = 1;
    endtask

    task automatic t_aoff_off;
        int h;
        set_pd(10, 10);
        count_high(200, h);
        check("R7 timeout 0xFFFF never stops output", h, 200);
    endtask

    task automatic t_aoff_expire;
        int h;
        wr(8'hA1, 8'h00);
        wr(8'hA2, 8'h03);
        repeat (9) @(negedge clk);
        check("R8 still running before 3 ms", 32'(pwm_out), 1);
        repeat (8) @(negedge clk);
        check("R8 stopped after 3 ms", 32'(pwm_out), 0);
        count_high(40, h);
        check("R8 stays off after expiry", h, 0);
        wr(8'hA3, 8'h01);
        @(negedge clk);
        check("R8 re-enable runs briefly", 32'(pwm_out), 1);
        repeat (8) @(negedge clk);
        check("R8 expired timer stops at next ms", 32'(pwm_out), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset;
        t_basic;
        t_staging;
        t_full;
        t_zero;
        t_enable;
        t_unmapped;
        t_tick;
        t_aoff_off;
        t_aoff_expire;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule